// File: doc/BRIEF.md
# Display Command Sequence Engine

This block steps through a fixed table of display panel commands held in a small internal ROM and sends each one to the panel as a single-wire SPI write. The ROM is a flat byte stream. Each entry gives an instruction byte, a register index, a 16-bit delay in milliseconds, a 16-bit payload count, and then the payload bytes. For each entry the block lowers chip select and sends a four-byte header followed by the payload. It then raises chip select and waits the stated delay before it reads the next entry. A zero instruction byte marks the end of the table.

Software or a power-management sequencer selects one of two tables and pulses `start`. `busy` stays high for the whole walk. `done` pulses once when the end marker is reached. Table 0 brings the panel up: sleep-out, column and row window, tear line, a 16-bit pixel format, tear-effect mode, brightness control, then display-on. Table 1 shuts it down: display-off, then sleep-in. The SPI clock divider and the millisecond prescaler are parameters. Payload counts up to `MAX_PAYLOAD` (300 by default) are supported.

Top module: `disp_cmd_seq`

## Requirements
- R1: Every transmitted entry starts with four header bytes in this order: the instruction byte, 0x00, the register index, 0x00. The index therefore sits in bits [15:8] of a 24-bit address. Both tables use instruction 0x02 (single-wire write).
- R2: After the header come exactly as many payload bytes as the entry's count, in ROM order. A count of zero sends the header alone.
- R3: `spi_cs_n` goes low before the first header bit of an entry and returns high after its last payload bit. It is never held low across two entries. Each low period carries a whole number of bytes and occurs only while `busy` is high.
- R4: The number of clocks from `spi_cs_n` rising to the next `spi_cs_n` falling, or to `done`, lies between D×CLK_PER_MS and D×CLK_PER_MS+16, where D is the entry's delay in milliseconds. A delay of zero adds no wait.
- R5: An entry whose instruction byte is 0x00 ends the walk and is not transmitted. `done` is a single-cycle pulse, and `busy` is low in that cycle.
- R6: SPI mode 0, MSB first. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` is stable while `spi_sck` is high. Each `spi_sck` high phase lasts SCK_HALF clocks.
- R7: `start` is accepted only while `busy` is low, and `table_sel` is sampled only at that moment. A start pulse during a walk changes neither the running sequence nor what follows it.
- R8: Table 0 (select 0) has eight entries. Each is listed as index/delay/payload:
  - 0x11/10 ms/none
  - 0x2A/1/{00,00,01,6F}
  - 0x2B/1/{00,00,01,BF}
  - 0x44/1/{01,BF}
  - 0x3A/1/{05}
  - 0x35/1/{00}
  - 0x53/25/{20}
  - 0x29/1/none

  Table 1 (select 1) has two entries: 0x28/15/none and 0x10/0/none.
- R9: While `rst_n` is low and after reset: `spi_cs_n` is high, and `spi_sck`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to walk the selected table |
| table_sel | input | 1 | Table choice: 0 power-up, 1 power-down |
| busy | output | 1 | High while a table is being walked |
| done | output | 1 | One-cycle pulse at the end of a walk |
| spi_cs_n | output | 1 | Panel chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data out, MSB first |

## Verification
The bound checker watches the relations that hold in every cycle:
- SCK stays idle outside chip select.
- MOSI holds steady through each high phase of SCK.
- Chip select is low only while busy.
- Done is a lone pulse with busy low.
- Busy rises only after a start request.

Byte content, header order, payload counts, the millisecond gaps, and the proof that a mid-walk start and a table-select change are ignored can only be shown by the bench. It decodes each chip-select frame at the pins and compares it, and the gap that follows it, with a model built from the table contents.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_INS, ST_IDX, ST_DLY_H, ST_DLY_L,
        ST_CNT_H, ST_CNT_L, ST_SEND, ST_SHIFT, ST_WAIT
    } seq_st_e;

    localparam int unsigned DLY_W  = 16;
    localparam logic [7:0]  OP_WR  = 8'h02;
    localparam logic [7:0]  OP_END = 8'h00;

    // entry layout: op, index, delay[15:8], delay[7:0], count[15:8], count[7:0], payload
    localparam logic [7:0] TBL_ON [0:61] = '{
        OP_WR, 8'h11, 8'h00, 8'h0A, 8'h00, 8'h00,
        OP_WR, 8'h2A, 8'h00, 8'h01, 8'h00, 8'h04, 8'h00, 8'h00, 8'h01, 8'h6F,
        OP_WR, 8'h2B, 8'h00, 8'h01, 8'h00, 8'h04, 8'h00, 8'h00, 8'h01, 8'hBF,
        OP_WR, 8'h44, 8'h00, 8'h01, 8'h00, 8'h02, 8'h01, 8'hBF,
        OP_WR, 8'h3A, 8'h00, 8'h01, 8'h00, 8'h01, 8'h05,
        OP_WR, 8'h35, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00,
        OP_WR, 8'h53, 8'h00, 8'h19, 8'h00, 8'h01, 8'h20,
        OP_WR, 8'h29, 8'h00, 8'h01, 8'h00, 8'h00,
        OP_END
    };

    localparam logic [7:0] TBL_OFF [0:12] = '{
        OP_WR, 8'h28, 8'h00, 8'h0F, 8'h00, 8'h00,
        OP_WR, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00,
        OP_END
    };

    function automatic logic [7:0] rom_byte(input logic sel, input logic [7:0] a);
        logic [7:0] b;
        b = OP_END;
        if (!sel) begin
            if (a < 8'd62) b = TBL_ON[a[5:0]];
        end else begin
            if (a < 8'd13) b = TBL_OFF[a[3:0]];
        end
        return b;
    endfunction

endpackage

// File: rtl/seq_rom.sv
module seq_rom #(
    parameter int unsigned AW = 7
) (
    input  logic          sel,
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    import disp_seq_pkg::*;

    always_comb begin
        data = rom_byte(sel, 8'(addr));
    end
endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx #(
    parameter int unsigned SCK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] din,
    output logic       sck,
    output logic       mosi,
    output logic       fin
);
    localparam int unsigned HW = $clog2(SCK_HALF + 1);

    typedef struct packed {
        logic          active;
        logic          sck;
        logic          fin;
        logic [2:0]    bitn;
        logic [HW-1:0] cnt;
        logic [7:0]    sh;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.active) begin
            if (go) begin
                d.active = 1'b1;
                d.sh     = din;
                d.bitn   = '0;
                d.cnt    = '0;
                d.sck    = 1'b0;
            end
        end else if (q.cnt == HW'(SCK_HALF - 1)) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
            end else begin
                d.sck = 1'b0;
                if (q.bitn == 3'd7) begin
                    d.active = 1'b0;
                    d.fin    = 1'b1;
                end else begin
                    d.bitn = q.bitn + 3'd1;
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.cnt = q.cnt + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.sh[7];
    assign fin  = q.fin;
endmodule

// File: rtl/ms_wait.sv
module ms_wait #(
    parameter int unsigned CLK_PER_MS = 100000,
    parameter int unsigned DLY_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [DLY_W-1:0] ms,
    output logic             fin
);
    localparam int unsigned TW = $clog2(CLK_PER_MS + 1);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [DLY_W-1:0] left;
        logic [TW-1:0]    tick;
    } wt_t;

    wt_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.run) begin
            if (arm) begin
                if (ms == '0) begin
                    d.fin = 1'b1;
                end else begin
                    d.run  = 1'b1;
                    d.left = ms;
                    d.tick = '0;
                end
            end
        end else if (q.tick == TW'(CLK_PER_MS - 1)) begin
            d.tick = '0;
            if (q.left == DLY_W'(1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end else begin
                d.left = q.left - DLY_W'(1);
            end
        end else begin
            d.tick = q.tick + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
endmodule

// File: rtl/disp_cmd_seq.sv
module disp_cmd_seq #(
    parameter int unsigned CLK_PER_MS  = 100000,
    parameter int unsigned SCK_HALF    = 4,
    parameter int unsigned MAX_PAYLOAD = 300,
    parameter int unsigned ROM_AW      = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic table_sel,
    output logic busy,
    output logic done,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi
);
    import disp_seq_pkg::*;

    localparam int unsigned CW = $clog2(MAX_PAYLOAD + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              tsel;
        logic [ROM_AW-1:0] ptr;
        logic [7:0]        op;
        logic [7:0]        idx;
        logic [7:0]        hi;
        logic [DLY_W-1:0]  dly;
        logic [CW-1:0]     cnt;
        logic [2:0]        hdr;
        logic              go;
        logic [7:0]        tx;
        logic              arm;
        logic              cs_n;
        logic              busy;
        logic              done;
    } ctl_t;

    ctl_t q, d;
    logic [7:0] rom_q;
    logic       byte_fin;
    logic       wait_fin;

    seq_rom #(.AW(ROM_AW)) u_rom (
        .sel  (q.tsel),
        .addr (q.ptr),
        .data (rom_q)
    );

    spi_byte_tx #(.SCK_HALF(SCK_HALF)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (q.go),
        .din  (q.tx),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .fin  (byte_fin)
    );

    ms_wait #(.CLK_PER_MS(CLK_PER_MS), .DLY_W(DLY_W)) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (q.arm),
        .ms   (q.dly),
        .fin  (wait_fin)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.arm  = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: if (start) begin
                d.st   = ST_INS;
                d.tsel = table_sel;
                d.ptr  = '0;
                d.busy = 1'b1;
            end
            ST_INS: if (rom_q == OP_END) begin
                d.st   = ST_IDLE;
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.op  = rom_q;
                d.ptr = q.ptr + ROM_AW'(1);
                d.st  = ST_IDX;
            end
            ST_IDX: begin
                d.idx = rom_q;
                d.ptr = q.ptr + ROM_AW'(1);
                d.st  = ST_DLY_H;
            end
            ST_DLY_H: begin
                d.hi  = rom_q;
                d.ptr = q.ptr + ROM_AW'(1);
                d.st  = ST_DLY_L;
            end
            ST_DLY_L: begin
                d.dly = {q.hi, rom_q};
                d.ptr = q.ptr + ROM_AW'(1);
                d.st  = ST_CNT_H;
            end
            ST_CNT_H: begin
                d.hi  = rom_q;
                d.ptr = q.ptr + ROM_AW'(1);
                d.st  = ST_CNT_L;
            end
            ST_CNT_L: begin
                d.cnt  = CW'({q.hi, rom_q});
                d.ptr  = q.ptr + ROM_AW'(1);
                d.hdr  = '0;
                d.cs_n = 1'b0;
                d.st   = ST_SEND;
            end
            ST_SEND: if (q.hdr != 3'd4) begin
                d.go  = 1'b1;
                d.tx  = (q.hdr == 3'd0) ? q.op : (q.hdr == 3'd2) ? q.idx : 8'h00;
                d.hdr = q.hdr + 3'd1;
                d.st  = ST_SHIFT;
            end else if (q.cnt != '0) begin
                d.go  = 1'b1;
                d.tx  = rom_q;
                d.ptr = q.ptr + ROM_AW'(1);
                d.cnt = q.cnt - CW'(1);
                d.st  = ST_SHIFT;
            end else begin
                d.cs_n = 1'b1;
                d.arm  = 1'b1;
                d.st   = ST_WAIT;
            end
            ST_SHIFT: if (byte_fin) d.st = ST_SEND;
            ST_WAIT:  if (wait_fin) d.st = ST_INS;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign spi_cs_n = q.cs_n;
endmodule

// File: rtl/disp_cmd_seq_chk.sv
module disp_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);                                   // R6
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));       // R6
    AST_CS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);                                      // R3
    AST_CS_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !spi_sck);                            // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && spi_cs_n));                            // R5
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));                            // R7
endmodule

bind disp_cmd_seq disp_cmd_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .spi_cs_n(spi_cs_n),
    .spi_sck (spi_sck),
    .spi_mosi(spi_mosi)
);

// File: tb/disp_cmd_seq_bench.sv
`timescale 1ns/100ps
module disp_cmd_seq_bench;
    localparam int CPM  = 20;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n, start, table_sel;
    logic busy, done, spi_cs_n, spi_sck, spi_mosi;

    always #2.5 clk = ~clk;

    disp_cmd_seq #(.CLK_PER_MS(CPM), .SCK_HALF(HALF)) u_disp_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .table_sel(table_sel),
        .busy(busy), .done(done), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0, frames_run = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    int exp_len[$], exp_dly[$];
    logic [7:0] got[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic add_ent(input logic [7:0] idx, input int dly, input int n, input logic [31:0] pl);
        exp_q.push_back(8'h02); exp_q.push_back(8'h00);
        exp_q.push_back(idx);   exp_q.push_back(8'h00);
        for (int i = 0; i < n; i++) exp_q.push_back(pl[31-8*i -: 8]);
        exp_len.push_back(4 + n);
        exp_dly.push_back(dly);
    endtask

    task automatic load_on();   // R8 power-up table
        add_ent(8'h11, 10, 0, 32'h0);
        add_ent(8'h2A, 1, 4, 32'h0000016F);
        add_ent(8'h2B, 1, 4, 32'h000001BF);
        add_ent(8'h44, 1, 2, 32'h01BF0000);
        add_ent(8'h3A, 1, 1, 32'h05000000);
        add_ent(8'h35, 1, 1, 32'h00000000);
        add_ent(8'h53, 25, 1, 32'h20000000);
        add_ent(8'h29, 1, 0, 32'h0);
    endtask

    task automatic load_off();  // R8 power-down table
        add_ent(8'h28, 15, 0, 32'h0);
        add_ent(8'h10, 0, 0, 32'h0);
    endtask

    // pin-level monitor and per-clock comparison
    logic prev_sck = 0, prev_cs = 1, prev_done = 0;
    logic [7:0] cur = 0;
    int nbit = 0, hi_len = 0, last_rise = 0, last_dly = 0;
    bit have_rise = 0;

    task automatic gap_check();
        int g, lo;
        g  = cyc - last_rise;
        lo = last_dly * CPM;
        check(g >= lo && g <= lo + 16, (last_dly == 0) ? "R4 zero-delay gap" : "R4 delay gap", g, lo);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(!(spi_cs_n && spi_sck), "R6 sck idle low", spi_sck, 0);
            check(spi_cs_n || busy, "R3 cs only while busy", busy, 1);
            if (spi_sck) hi_len++;
            if (prev_sck && !spi_sck) begin
                check(hi_len == HALF, "R6 sck high phase", hi_len, HALF);
                hi_len = 0;
            end
            if (!prev_sck && spi_sck && !spi_cs_n) begin
                cur = {cur[6:0], spi_mosi};
                nbit++;
                if (nbit % 8 == 0) got.push_back(cur);
            end
            if (prev_cs && !spi_cs_n) begin
                if (have_rise) gap_check();
                got.delete();
                nbit = 0;
            end
            if (!prev_cs && spi_cs_n) begin
                frames_run++;
                if (exp_len.size() == 0) begin
                    check(0, "R5 frame after end marker", frames_run, 0);
                end else begin
                    int len;
                    len = exp_len.pop_front();
                    check(nbit == 8 * len, "R3 bits per frame", nbit, 8 * len);
                    for (int i = 0; i < len; i++) begin
                        int a, e;
                        e = int'(exp_q.pop_front());
                        a = (i < got.size()) ? int'(got[i]) : -1;
                        check(a == e, (i < 4) ? "R1 header byte" : "R2 payload byte", a, e);
                    end
                    last_dly = exp_dly.pop_front();
                end
                last_rise = cyc;
                have_rise = 1;
            end
            if (done) begin
                check(!prev_done, "R5 done single pulse", prev_done, 0);
                check(!busy, "R5 busy low at done", busy, 0);
                check(exp_len.size() == 0, "R5 all entries sent", exp_len.size(), 0);
                if (have_rise) gap_check();
                have_rise = 0;
                done_cnt++;
            end
        end
        prev_sck  = spi_sck;
        prev_cs   = spi_cs_n;
        prev_done = done;
    end

    task automatic pulse_start(input logic sel);
        start = 1'b1; table_sel = sel;
        @(negedge clk);
        start = 1'b0; table_sel = 1'b0;
    endtask

    task automatic wait_done();
        int target;
        target = done_cnt + 1;
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; table_sel = 1'b0;
        repeat (5) @(negedge clk);
        check(spi_cs_n == 1'b1, "R9 reset cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R9 reset sck", spi_sck, 0);
        check(busy == 1'b0, "R9 reset busy", busy, 0);
        check(done == 1'b0, "R9 reset done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // power-up walk with a stray start/select mid-run (R7)
        load_on();
        frames_run = 0;
        pulse_start(1'b0);
        repeat (150) @(negedge clk);
        check(busy == 1'b1, "R7 busy during walk", busy, 1);
        pulse_start(1'b1);
        wait_done();
        check(frames_run == 8, "R8 power-up entry count", frames_run, 8);
        repeat (60) @(negedge clk);
        check(spi_cs_n && !busy, "R7 no restart after stray start", busy, 0);
        check(frames_run == 8, "R7 no extra frames", frames_run, 8);

        // power-down walk, includes a zero delay
        load_off();
        frames_run = 0;
        pulse_start(1'b1);
        wait_done();
        check(frames_run == 2, "R8 power-down entry count", frames_run, 2);

        // back-to-back power-up walk
        load_on();
        frames_run = 0;
        pulse_start(1'b0);
        wait_done();
        check(frames_run == 8, "R8 repeated power-up count", frames_run, 8);
        check(done_cnt == 3, "R5 one done per walk", done_cnt, 3);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule